// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block serializes characters onto an asynchronous serial line. A one-entry holding buffer sits in front of a frame shifter, so software can hand over the next character while the current one is still going out. Characters are 5 to 9 data bits long. The ninth bit does not travel on the data bus. It is taken from a control bit that software sets or clears before it writes the low byte. In multiprocessor links a ninth bit of 1 marks an address frame.

A small write-only register port sits on the bus side. It takes the data byte, a control byte and a status byte. Two flags come out as plain outputs. One shows that the holding buffer is empty. The other shows that the last frame has fully left the line. Each flag has its own interrupt output, gated by an enable bit. Bit timing comes from an external one-cycle baud tick, so each line bit lasts one tick interval.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `buf_empty` is 1, `tx_done` is 0 and both interrupt outputs are 0. The control register resets with a length code of 3 and all other control bits at 0.
- R2: A write to address 0 while `buf_empty` is 1 stores `wr_data` together with control bit 0 (the ninth bit). `buf_empty` is 0 from the next cycle.
- R3: A write to address 0 while `buf_empty` is 0 is ignored. The buffered character is kept and is the one that gets transmitted.
- R4: When the shifter is idle and the buffer is full, the character moves into the shifter on the next baud tick. At that edge `buf_empty` becomes 1 and `txd` becomes 0 (the start bit).
- R5: A frame is made of a start bit of 0, then the data bits LSB first, then the stop bits of 1. The number of data bits is set by control bits [6:4]: codes 0 to 4 give 5 to 9 bits, and codes 5 to 7 give 8 bits. The ninth data bit is control bit 0 as it stood at the data write. Control bit 3 selects two stop bits. Each bit lasts exactly one baud-tick interval, and the line idles at 1.
- R6: If the buffer is full on the tick that ends the last stop bit, the next start bit begins on that same tick, with no idle time between the frames.
- R7: `tx_done` becomes 1 on the tick that ends the last stop bit, but only when no character is waiting in the buffer.
- R8: `tx_done` is cleared by a write to address 2 with bit 0 set, or by a one-cycle `done_ack` pulse. Bit 1 of that write has no effect. If a clear and a set fall in the same cycle, the set wins.
- R9: `irq_empty` is a level equal to `buf_empty` AND control bit 1. `irq_done` is a level equal to `tx_done` AND control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse, one per bit interval |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| wr_data | input | 8 | Write data |
| done_ack | input | 1 | Interrupt-taken pulse that clears `tx_done` |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer empty flag |
| tx_done | output | 1 | Frame fully sent flag |
| irq_empty | output | 1 | Buffer-empty interrupt (level) |
| irq_done | output | 1 | Transmit-complete interrupt (level) |

## Verification
Two pairs of events can land on the same edge. In the first, the tick that ends the last stop bit sets `tx_done` while `done_ack` (or a status clear) tries to clear it. The bench holds `done_ack` high across the end of a frame, so the set must win on that edge and the clear must take effect one cycle later. In the second, a data write arrives on the very tick that moves the buffered character into the shifter. That write sees a full buffer and must be dropped, so the bench writes on every cycle around the load. A behavioural reference model, fed the same inputs, predicts every output on every clock, so any wrong choice of winner shows up as a mismatch in the following cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MAX_DATA = 9;
  localparam int MAX_STOP = 2;
  localparam int FRAME_W  = 1 + MAX_DATA + MAX_STOP;
  localparam int CNT_W    = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic [2:0] len_code;
    logic       two_stop;
    logic       ie_done;
    logic       ie_empty;
    logic       bit8;
  } ctrl_t;

  function automatic int data_bits(input logic [2:0] code);
    return (code <= 3'd4) ? int'(code) + 5 : 8;
  endfunction
endpackage

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [6:0] ctrl_data,
  input  logic       stat_we,
  input  logic       stat_clr,
  input  logic       done_set,
  input  logic       done_ack,
  input  logic       buf_empty,
  output ctrl_t      cfg,
  output logic       done_q,
  output logic       irq_empty,
  output logic       irq_done
);
  logic clr_req;
  assign clr_req = done_ack || (stat_we && stat_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '{len_code: 3'd3, two_stop: 1'b0, ie_done: 1'b0, ie_empty: 1'b0, bit8: 1'b0};
    end else if (ctrl_we) begin
      cfg <= ctrl_t'(ctrl_data);
    end
  end

  // set has priority over any clear request in the same cycle
  always_ff @(posedge clk) begin
    if (rst)           done_q <= 1'b0;
    else if (done_set) done_q <= 1'b1;
    else if (clr_req)  done_q <= 1'b0;
  end

  assign irq_empty = buf_empty && cfg.ie_empty;
  assign irq_done  = done_q && cfg.ie_done;

  a_r7_done_sets: assert property (@(posedge clk) disable iff (rst)
    done_set |=> done_q);
  a_r8_done_clears: assert property (@(posedge clk) disable iff (rst)
    (!done_set && clr_req) |=> !done_q);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bit8,
  input  logic              take,
  output logic              empty_q,
  output logic [DATA_W:0]   hold_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      hold_q  <= '0;
    end else if (take) begin
      empty_q <= 1'b1;
    end else if (data_we && empty_q) begin
      hold_q  <= {bit8, wdata};
      empty_q <= 1'b0;
    end
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (data_we && empty_q) |=> (!empty_q && hold_q == {$past(bit8), $past(wdata)}));
  a_r3_keep_buffer: assert property (@(posedge clk) disable iff (rst)
    (data_we && !empty_q) |=> (hold_q == $past(hold_q)));
  a_r4_empty_on_take: assert property (@(posedge clk) disable iff (rst)
    take |=> empty_q);
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            full,
  input  logic [DATA_W:0] hold,
  input  logic [2:0]      len_code,
  input  logic            two_stop,
  output logic            txd_q,
  output logic            take,
  output logic            frame_end
);
  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   left_q;
  logic [CNT_W-1:0]   left_init;
  logic               busy_q;
  logic               last;
  int                 nbits;

  always_comb begin
    nbits = data_bits(len_code);
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (i < nbits && i <= DATA_W) frame[i+1] = hold[i];
    end
    left_init = CNT_W'(nbits + (two_stop ? 2 : 1));
  end

  assign last      = busy_q && (left_q == '0);
  assign take      = tick && full && (!busy_q || last);
  assign frame_end = tick && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      sh_q   <= '1;
      left_q <= '0;
    end else if (tick) begin
      if (busy_q && left_q != '0) begin
        txd_q  <= sh_q[0];
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
      end else if (full) begin
        txd_q  <= frame[0];
        sh_q   <= {1'b1, frame[FRAME_W-1:1]};
        left_q <= left_init;
        busy_q <= 1'b1;
      end else begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end
    end
  end

  a_r4_start_bit: assert property (@(posedge clk) disable iff (rst)
    take |=> (!txd_q && busy_q));
  a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> txd_q);
  a_r6_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (frame_end && full) |=> (busy_q && !txd_q));
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              done_ack,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done,
  output logic              irq_empty,
  output logic              irq_done
);
  ctrl_t           cfg;
  logic            data_we, ctrl_we, stat_we;
  logic            take, frame_end;
  logic [DATA_W:0] hold;

  assign data_we = wr_en && (wr_addr == REG_DATA);
  assign ctrl_we = wr_en && (wr_addr == REG_CTRL);
  assign stat_we = wr_en && (wr_addr == REG_STAT);

  uart_tx_cfg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .ctrl_we   (ctrl_we),
    .ctrl_data (wr_data[6:0]),
    .stat_we   (stat_we),
    .stat_clr  (wr_data[0]),
    .done_set  (frame_end && buf_empty),
    .done_ack  (done_ack),
    .buf_empty (buf_empty),
    .cfg       (cfg),
    .done_q    (tx_done),
    .irq_empty (irq_empty),
    .irq_done  (irq_done)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .data_we (data_we),
    .wdata   (wr_data),
    .bit8    (cfg.bit8),
    .take    (take),
    .empty_q (buf_empty),
    .hold_q  (hold)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .full      (!buf_empty),
    .hold      (hold),
    .len_code  (cfg.len_code),
    .two_stop  (cfg.two_stop),
    .txd_q     (txd),
    .take      (take),
    .frame_end (frame_end)
  );
endmodule

// File: tb/uart_tx_dbuf_bench.sv
module uart_tx_dbuf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BAUD_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       done_ack = 1'b0;
  logic       txd, buf_empty, tx_done, irq_empty, irq_done;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_dbuf u_uart_tx_dbuf (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .done_ack(done_ack),
    .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done),
    .irq_empty(irq_empty), .irq_done(irq_done)
  );

  // baud tick every BAUD_DIV cycles
  int bcnt = 0;
  always @(negedge clk) begin
    bcnt = (bcnt + 1) % BAUD_DIV;
    baud_tick <= (bcnt == 0);
  end

  // behavioural reference model
  bit m_empty, m_busy, m_txd, m_done, m_b2b;
  bit m_b8, m_iee, m_ied, m_two;
  int m_len;
  bit [8:0] m_hold;
  bit m_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_empty = 1; m_busy = 0; m_txd = 1; m_done = 0; m_b2b = 0;
      m_b8 = 0; m_iee = 0; m_ied = 0; m_two = 0; m_len = 3;
      m_q.delete();
    end else begin
      bit old_empty, set_done, was_end;
      int n;
      old_empty = m_empty;
      set_done = 0;
      if (baud_tick) begin
        if (m_busy && m_q.size() > 0) begin
          m_txd = m_q.pop_front();
        end else begin
          was_end = m_busy;
          if (!m_empty) begin
            n = (m_len <= 4) ? m_len + 5 : 8;
            m_q.delete();
            for (int i = 0; i < n; i++) m_q.push_back(m_hold[i]);
            m_q.push_back(1'b1);
            if (m_two) m_q.push_back(1'b1);
            m_txd = 0; m_busy = 1; m_empty = 1; m_b2b = was_end;
          end else begin
            if (m_busy) set_done = 1;
            m_busy = 0; m_txd = 1; m_b2b = 0;
          end
        end
      end
      if (wr_en && wr_addr == 2'd0 && old_empty) begin
        m_hold = {m_b8, wr_data}; m_empty = 0;
      end
      if (set_done) m_done = 1;
      else if (done_ack || (wr_en && wr_addr == 2'd2 && wr_data[0])) m_done = 0;
      if (wr_en && wr_addr == 2'd1) begin
        m_b8 = wr_data[0]; m_iee = wr_data[1]; m_ied = wr_data[2];
        m_two = wr_data[3]; m_len = int'(wr_data[6:4]);
      end
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check_eq(m_b2b ? "R6 txd" : "R5 txd", txd, m_txd);
      check_eq("R4 buf_empty", buf_empty, m_empty);
      check_eq("R7 tx_done", tx_done, m_done);
      check_eq("R9 irq_empty", irq_empty, m_empty && m_iee);
      check_eq("R9 irq_done", irq_done, m_done && m_ied);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [7:0] ctl(input int len, input bit two, input bit ied,
                                     input bit iee, input bit b8);
    return {1'b0, 3'(len), two, ied, iee, b8};
  endfunction

  task automatic wait_idle();
    do @(negedge clk); while (!(m_empty && !m_busy));
    repeat (BAUD_DIV) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1 txd", txd, 1);
    check_eq("R1 buf_empty", buf_empty, 1);
    check_eq("R1 tx_done", tx_done, 0);
    check_eq("R1 irq_empty", irq_empty, 0);
    check_eq("R1 irq_done", irq_done, 0);
    rst = 0;

    // R5 default 8-bit frame, R9 irq enables
    wr(2'd1, ctl(3, 0, 1, 1, 0));
    wr(2'd0, 8'hA5);
    check_eq("R2 buf_empty after write", buf_empty, 0);
    wait_idle();
    check_eq("R7 done after frame", tx_done, 1);

    // R8 bit1 of status write ignored, bit0 clears
    wr(2'd2, 8'h02);
    check_eq("R8 bit1 no effect", tx_done, 1);
    wr(2'd2, 8'h01);
    check_eq("R8 write-one clear", tx_done, 0);

    // R5 nine bits with ninth bit 1 and two stops
    wr(2'd1, ctl(4, 1, 1, 0, 1));
    wr(2'd0, 8'h3C);
    wait_idle();
    @(negedge clk); done_ack = 1; @(negedge clk); done_ack = 0;
    check_eq("R8 ack clear", tx_done, 0);

    // five-bit characters and out-of-range code
    wr(2'd1, ctl(0, 0, 0, 1, 0));
    wr(2'd0, 8'hFF);
    wait_idle();
    wr(2'd1, ctl(6, 0, 1, 1, 0));
    wr(2'd0, 8'h81);
    wait_idle();

    // R6 back-to-back, R3 write while full ignored
    wr(2'd0, 8'h11);
    do @(negedge clk); while (!m_busy);
    wr(2'd0, 8'h22);
    wr(2'd0, 8'h33);  // R3: buffer full, dropped
    check_eq("R3 buffer still full", buf_empty, 0);
    // R8 set/clear coincidence: hold ack across the end of frame
    done_ack = 1;
    wait_idle();
    done_ack = 0;
    repeat (2) @(negedge clk);

    // write on every cycle around a load: writes at the load edge are dropped
    wr(2'd0, 8'h5A);
    for (int k = 0; k < 3 * BAUD_DIV; k++) begin
      @(negedge clk); wr_en = 1; wr_addr = 2'd0; wr_data = 8'(k + 8'h60);
    end
    @(negedge clk); wr_en = 0;
    wait_idle();
    wait_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule